// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two independent direction predictors. The per-branch predictor remembers the recent outcomes of each branch in a first-level history table and uses that history to select a 2-bit saturating counter. The path predictor keeps one shift register of the most recent outcomes of all branches and uses it to select a counter in a larger table. A third table of 2-bit saturating counters, the selector, is indexed by the path history. It learns which of the two predictors is more reliable in that context, and its value steers a mux that produces the final direction.

A fetch stage presents a PC on the lookup port and receives the final direction in the same cycle. It also receives both component predictions for debug. When a branch resolves, the back end presents its PC and outcome on the training port. Both component predictors learn from every resolved branch. The selector learns only when the two components disagreed. All history is non-speculative: the histories shift only on resolved outcomes. A training event becomes visible to lookups from the next clock cycle.

Top module: `tbp_predictor`

## Requirements
- R1: After reset every history bit is 0, every direction counter holds 1 and every selector counter holds 1, so every lookup returns not-taken from all three outputs and the selector chooses the per-branch predictor.
- R2: The per-branch predictor selects a 10-bit history entry with PC bits [11:2]. That history directly addresses a 1024-entry counter table. On training, the outcome enters at bit 0 of the history of the trained PC (1 = taken) and the older bits move up by one.
- R3: The path history is 12 bits wide and addresses a 4096-entry counter table. Each training event shifts the outcome in at bit 0.
- R4: Every 2-bit counter stops at 0 and at 3. A direction counter predicts taken when its value is 2 or 3.
- R5: The selector counter is addressed by the path history. A value of 2 or 3 makes the final direction equal the path prediction, and 0 or 1 makes it equal the per-branch prediction.
- R6: The selector counter changes only when the two components predicted differently for the trained branch. It counts up when the path prediction matched the outcome and down when the per-branch prediction did, stopping at 0 and 3.
- R7: On every training event both component counters move toward the outcome, whichever component was selected.
- R8: A lookup reflects the state before any training presented in the same cycle. The effect of training appears on lookups from the following cycle.
- R9: While training is not requested, the training PC and outcome have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pc_i | input | 32 | PC of the branch being looked up |
| pred_taken_o | output | 1 | Final direction (1 = taken) |
| pred_local_o | output | 1 | Per-branch component direction |
| pred_global_o | output | 1 | Path component direction |
| upd_valid_i | input | 1 | Training request |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome (1 = taken) |

## Verification
Lookups and training can share a cycle, and they can touch the same history entry or the same counter. The directed collision case trains one branch and, in the same cycle, looks up a second branch whose history aliases onto the counter being trained. That lookup must still return the old value, and the next lookup must show the new one. The long mixed run issues a lookup every cycle, usually alongside a training request for a related or aliasing PC. A model built from the requirements checks every output in every cycle, using the state before that cycle's training.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_INIT = 2'd1;

    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        ctr2_t r;
        if (up) begin
            r = (c == 2'd3) ? c : c + 2'd1;
        end else begin
            r = (c == 2'd0) ? c : c - 2'd1;
        end
        return r;
    endfunction

    function automatic logic ctr_high(input ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned HIST_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [HIST_W-1:0] rd_hist_o,
    input  logic [IDX_W-1:0]  upd_idx_i,
    output logic [HIST_W-1:0] upd_hist_o,
    input  logic              upd_en_i,
    input  logic              upd_bit_i
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [HIST_W-1:0] val;
    } hwr_t;

    logic [HIST_W-1:0] hist_q [DEPTH];
    logic [HIST_W-1:0] shifted;
    hwr_t              wr_d;

    generate
        if (HIST_W > 1) begin : g_shift
            assign shifted = {upd_hist_o[HIST_W-2:0], upd_bit_i};
        end else begin : g_single
            assign shifted = upd_bit_i;
        end
    endgenerate

    always_comb begin
        rd_hist_o  = hist_q[rd_idx_i];
        upd_hist_o = hist_q[upd_idx_i];
        wr_d.en    = upd_en_i;
        wr_d.idx   = upd_idx_i;
        wr_d.val   = shifted;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_q[i] <= '0;
            end
        end else if (wr_d.en) begin
            hist_q[wr_d.idx] <= wr_d.val;
        end
    end

endmodule

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
    import tbp_pkg::*;
#(
    parameter int unsigned IDX_W = 10,
    parameter ctr2_t       INIT  = CTR_INIT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] rd_idx_i,
    output ctr2_t            rd_ctr_o,
    input  logic [IDX_W-1:0] upd_idx_i,
    output ctr2_t            upd_ctr_o,
    input  logic             upd_en_i,
    input  logic             upd_up_i
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        ctr2_t            val;
    } cwr_t;

    ctr2_t tbl_q [DEPTH];
    cwr_t  wr_d;

    always_comb begin
        rd_ctr_o  = tbl_q[rd_idx_i];
        upd_ctr_o = tbl_q[upd_idx_i];
        wr_d.en   = upd_en_i;
        wr_d.idx  = upd_idx_i;
        wr_d.val  = ctr_step(upd_ctr_o, upd_up_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= INIT;
            end
        end else if (wr_d.en) begin
            tbl_q[wr_d.idx] <= wr_d.val;
        end
    end

endmodule

// File: rtl/tbp_predictor.sv
module tbp_predictor
    import tbp_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned LIDX_W  = 10,
    parameter int unsigned LHIST_W = 10,
    parameter int unsigned GHIST_W = 12
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PC_W-1:0] pc_i,
    output logic            pred_taken_o,
    output logic            pred_local_o,
    output logic            pred_global_o,
    input  logic            upd_valid_i,
    input  logic [PC_W-1:0] upd_pc_i,
    input  logic            upd_taken_i
);
    localparam int unsigned PC_LSB = 2;
    localparam int unsigned PC_MSB = PC_LSB + LIDX_W - 1;

    typedef struct packed {
        logic [GHIST_W-1:0] ghist;
    } state_t;

    state_t state_d, state_q;

    logic [GHIST_W-1:0] ghist;
    logic [LIDX_W-1:0]  rd_lidx, upd_lidx;
    logic [LHIST_W-1:0] rd_lhist, upd_lhist;
    ctr2_t              l2_rd, l2_upd, gt_rd, gt_upd, ch_rd, ch_upd_unused;
    logic               upd_lpred, upd_gpred;
    logic               ch_en, ch_up, sel_global;
    logic               pc_unused;

    assign ghist     = state_q.ghist;
    assign rd_lidx   = pc_i[PC_MSB:PC_LSB];
    assign upd_lidx  = upd_pc_i[PC_MSB:PC_LSB];
    assign pc_unused = ^{pc_i[PC_W-1:PC_MSB+1], pc_i[PC_LSB-1:0],
                         upd_pc_i[PC_W-1:PC_MSB+1], upd_pc_i[PC_LSB-1:0]};

    // first level of the per-branch component: one history per PC slot
    tbp_hist_table #(
        .IDX_W  (LIDX_W),
        .HIST_W (LHIST_W)
    ) i_lhist (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_idx_i   (rd_lidx),
        .rd_hist_o  (rd_lhist),
        .upd_idx_i  (upd_lidx),
        .upd_hist_o (upd_lhist),
        .upd_en_i   (upd_valid_i),
        .upd_bit_i  (upd_taken_i)
    );

    // second level of the per-branch component, addressed by the history
    tbp_ctr_table #(
        .IDX_W (LHIST_W),
        .INIT  (CTR_INIT)
    ) i_lctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_idx_i  (rd_lhist),
        .rd_ctr_o  (l2_rd),
        .upd_idx_i (upd_lhist),
        .upd_ctr_o (l2_upd),
        .upd_en_i  (upd_valid_i),
        .upd_up_i  (upd_taken_i)
    );

    // path component, addressed by the shared outcome history
    tbp_ctr_table #(
        .IDX_W (GHIST_W),
        .INIT  (CTR_INIT)
    ) i_gctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_idx_i  (ghist),
        .rd_ctr_o  (gt_rd),
        .upd_idx_i (ghist),
        .upd_ctr_o (gt_upd),
        .upd_en_i  (upd_valid_i),
        .upd_up_i  (upd_taken_i)
    );

    assign upd_lpred = ctr_high(l2_upd);
    assign upd_gpred = ctr_high(gt_upd);
    assign ch_en     = upd_valid_i && (upd_lpred != upd_gpred);
    assign ch_up     = (upd_gpred == upd_taken_i);

    // selector: high half trusts the path component
    tbp_ctr_table #(
        .IDX_W (GHIST_W),
        .INIT  (CTR_INIT)
    ) i_chooser (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_idx_i  (ghist),
        .rd_ctr_o  (ch_rd),
        .upd_idx_i (ghist),
        .upd_ctr_o (ch_upd_unused),
        .upd_en_i  (ch_en),
        .upd_up_i  (ch_up)
    );

    always_comb begin
        pred_local_o  = ctr_high(l2_rd);
        pred_global_o = ctr_high(gt_rd);
        sel_global    = ctr_high(ch_rd);
        pred_taken_o  = sel_global ? pred_global_o : pred_local_o;
    end

    always_comb begin
        state_d = state_q;
        if (upd_valid_i) begin
            state_d.ghist = {ghist[GHIST_W-2:0], upd_taken_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned GHIST_W = 12
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [PC_W-1:0]    pc_i,
    input logic               pred_taken_o,
    input logic               pred_local_o,
    input logic               pred_global_o,
    input logic               upd_valid_i,
    input logic               upd_taken_i,
    input logic [GHIST_W-1:0] ghist
);

    AST_RESET_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!pred_taken_o && !pred_local_o && !pred_global_o)); // R1

    AST_GHIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> (ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken_i)})); // R3

    AST_GHIST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_valid_i |=> $stable(ghist)); // R9

    AST_AGREE_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pred_local_o == pred_global_o) |-> (pred_taken_o == pred_local_o)); // R5

    AST_IDLE_PRED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_valid_i |=> (!$stable(pc_i) ||
                          $stable({pred_taken_o, pred_local_o, pred_global_o}))); // R8

endmodule

bind tbp_predictor tbp_checker #(
    .PC_W    (PC_W),
    .GHIST_W (GHIST_W)
) i_tbp_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pc_i          (pc_i),
    .pred_taken_o  (pred_taken_o),
    .pred_local_o  (pred_local_o),
    .pred_global_o (pred_global_o),
    .upd_valid_i   (upd_valid_i),
    .upd_taken_i   (upd_taken_i),
    .ghist         (ghist)
);

// File: tb/test_tbp_predictor.sv
`timescale 1ns/1ps
module test_tbp_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        p_taken, p_local, p_global;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    tbp_predictor i_tbp_predictor (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .pc_i          (pc),
        .pred_taken_o  (p_taken),
        .pred_local_o  (p_local),
        .pred_global_o (p_global),
        .upd_valid_i   (upd_valid),
        .upd_pc_i      (upd_pc),
        .upd_taken_i   (upd_taken)
    );

    // reference state written from the requirements
    logic [9:0]  m_lh [1024];
    logic [1:0]  m_l2 [1024];
    logic [1:0]  m_g  [4096];
    logic [1:0]  m_c  [4096];
    logic [11:0] m_gh;

    function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin m_lh[i] = '0; m_l2[i] = 2'd1; end
        for (int i = 0; i < 4096; i++) begin m_g[i] = 2'd1; m_c[i] = 2'd1; end
        m_gh = '0;
    endtask

    function automatic logic [2:0] model_pred(input logic [31:0] a);
        logic lp, gp, sel;
        lp  = m_l2[m_lh[a[11:2]]] >= 2'd2;
        gp  = m_g[m_gh] >= 2'd2;
        sel = m_c[m_gh] >= 2'd2;
        return {sel ? gp : lp, lp, gp};
    endfunction

    task automatic model_train(input logic [31:0] a, input logic t);
        logic [9:0] h;
        logic       lp, gp;
        h  = m_lh[a[11:2]];
        lp = m_l2[h] >= 2'd2;
        gp = m_g[m_gh] >= 2'd2;
        m_l2[h]    = sat(m_l2[h], t);
        m_g[m_gh]  = sat(m_g[m_gh], t);
        if (lp != gp) m_c[m_gh] = sat(m_c[m_gh], gp == t);
        m_lh[a[11:2]] = {h[8:0], t};
        m_gh          = {m_gh[10:0], t};
    endtask

    task automatic check3(input logic [2:0] exp, input string req);
        n_checks++;
        if ({p_taken, p_local, p_global} !== exp) begin
            n_fails++;
            $display("FAIL %s: {taken,local,global} actual=%b expected=%b at %0t",
                     req, {p_taken, p_local, p_global}, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // drive one cycle; outputs are stable 1 ns later, before the next edge
    task automatic drive(input logic v, input logic [31:0] ua, input logic t,
                         input logic [31:0] a);
        @(negedge clk);
        upd_valid = v; upd_pc = ua; upd_taken = t; pc = a;
        #1;
    endtask

    typedef struct packed {
        logic [7:0]  n_upd;
        logic [31:0] upc;
        logic        t;
        logic [31:0] ppc;
        logic [2:0]  exp;
    } vec_t;

    localparam logic [31:0] PA = 32'h0000_0100;
    localparam logic [31:0] PB = 32'h0000_0204;

    // after reset: n_upd trainings of upc with outcome t, then look up ppc
    localparam vec_t VECS [6] = '{
        '{8'd0,  PA, 1'b0, PA, 3'b000},  // R1 reset state
        '{8'd20, PA, 1'b1, PA, 3'b111},  // R2 R3 R4 saturated taken
        '{8'd20, PA, 1'b1, PB, 3'b111},  // R2 shared second level via zero history
        '{8'd5,  PA, 1'b0, PA, 3'b000},  // R4 low saturation
        '{8'd12, PA, 1'b1, PA, 3'b110},  // R5 disagree, selector low picks local
        '{8'd13, PA, 1'b1, PA, 3'b111}   // R7 path counter trained though not chosen
    };

    logic [31:0] lfsr = 32'h1234_5678;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        logic [31:0] pcs [5];
        logic        tog;
        logic [2:0]  e;
        pcs[0] = PA; pcs[1] = PB; pcs[2] = 32'h0000_0308;
        pcs[3] = 32'h0000_040C; pcs[4] = 32'h0000_1100;
        model_reset();

        for (int v = 0; v < 6; v++) begin
            do_reset();
            for (int k = 0; k < int'(VECS[v].n_upd); k++) begin
                drive(1'b1, VECS[v].upc, VECS[v].t, VECS[v].upc);
                model_train(VECS[v].upc, VECS[v].t);
            end
            drive(1'b0, '0, 1'b0, VECS[v].ppc);
            check3(VECS[v].exp, $sformatf("R1/R2/R4/R5/R7 vector %0d", v));
        end

        // R8: same-cycle training is not seen by the lookup
        do_reset();
        drive(1'b1, PA, 1'b1, PB);
        check3(3'b000, "R8 same-cycle lookup shows old state");
        model_train(PA, 1'b1);
        drive(1'b0, '0, 1'b0, PB);
        check3(3'b110, "R8 training visible next cycle");
        // R9: training inputs ignored without the request
        for (int k = 0; k < 10; k++) begin
            drive(1'b0, PB, k[0], PA);
        end
        drive(1'b0, PA, 1'b1, PB);
        check3(3'b110, "R9 idle training inputs leave state unchanged");
        drive(1'b0, '0, 1'b0, PA);
        check3(3'b000, "R9 idle lookup of trained PC");

        // long mixed run against the model: R5 R6 R7 R8
        do_reset();
        tog = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] ua, la;
            logic        v, t;
            int          sel;
            lfsr = nxt(lfsr);
            sel  = int'(lfsr[2:0]) % 5;
            ua   = pcs[sel];
            la   = pcs[int'(lfsr[10:8]) % 5];
            v    = lfsr[15:13] != 3'd0;
            case (sel)
                0: t = 1'b1;
                1: begin t = tog; if (v) tog = ~tog; end
                2: t = m_gh[1];
                3: t = lfsr[20];
                default: t = ~m_gh[0];
            endcase
            drive(v, ua, t, la);
            e = model_pred(la);
            check3(e, "R5/R6/R7 mixed run");
            if (v) model_train(ua, t);
        end

        drive(1'b0, '0, 1'b0, '0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule